// File: doc/BRIEF.md
# Mouse Event Packet Queue

This block turns each mouse event into a fixed five-byte serial mouse packet and stores the bytes in a circular receive queue. A host drains the queue one byte at a time. An event has a strobe, signed horizontal and vertical motion, and three button levels. A packer state machine accepts the event and writes the bytes into the queue, one byte per clock. While it is doing so, it refuses any new event.

The host always sees the oldest queued byte on `rd_data`, and `data_avail` tells it whether that byte is valid. A one-cycle `rd_en` pulse removes the byte. A synchronous `clr` empties the queue and aborts any packet that is still being written.

The packer has five states. `S_IDLE` waits for an event and writes the start byte in the cycle it accepts one (transition *accept*). `S_XMOT` writes the X byte (transition *x_done*). `S_YMOT` writes the Y byte (transition *y_done*). `S_PAD1` writes the first zero byte (transition *pad1_done*). `S_PAD2` writes the second zero byte and returns to `S_IDLE` (transition *finish*). A `clr` in any state takes the *abort* transition back to `S_IDLE`.

Top module: `mouse_pkt_fifo`

## Requirements
- R1: An event that is accepted in cycle t causes exactly five queue writes, in cycles t to t+4, in this order: start byte, X byte, Y byte, 0x00, 0x00.
- R2: The start byte is 0x87 with bit 2 cleared when `btn_left` is 1, bit 1 cleared when `btn_mid` is 1 and bit 0 cleared when `btn_right` is 1.
- R3: The X byte is `evt_dx` clamped to the range -127..+127 and written as 8-bit two's complement. Values above 127 give 0x7F and values below -127 give 0x81.
- R4: The Y byte is the negation of `evt_dy`, clamped and encoded the same way as the X byte.
- R5: An `evt_valid` that arrives while the packer is outside `S_IDLE` (cycles t+1 to t+4 after an acceptance) is ignored. The next event can be accepted at cycle t+5.
- R6: A byte written while the queue already holds DEPTH bytes at the start of the cycle is dropped, even if a read happens in the same cycle.
- R7: `rd_data` shows the oldest queued byte when the queue is not empty and 0x00 when it is empty. An `rd_en` on an empty queue changes nothing.
- R8: A write and a read in the same cycle on a queue that is neither empty nor full leave the occupancy unchanged and keep first-in first-out order.
- R9: `data_avail` is 1 exactly when the queue holds at least one byte, so it stays 1 after a read while bytes remain.
- R10: The read and write positions wrap from DEPTH-1 to 0, so first-in first-out order holds across wraps for any DEPTH of 2 or more, including depths that are not a power of two.
- R11: `clr` empties the queue and returns the packer to `S_IDLE` at the next edge. It takes priority over any event, write or read in the same cycle.
- R12: After reset the queue is empty, `data_avail` is 0, `rd_data` is 0x00 and the packer is in `S_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of the queue and the packer |
| evt_valid | input | 1 | Mouse event strobe |
| evt_dx | input | MW | Signed horizontal motion |
| evt_dy | input | MW | Signed vertical motion |
| btn_left | input | 1 | Left button pressed |
| btn_mid | input | 1 | Middle button pressed |
| btn_right | input | 1 | Right button pressed |
| rd_en | input | 1 | Removes the oldest byte |
| rd_data | output | 8 | Oldest queued byte, or 0 when empty |
| data_avail | output | 1 | Queue not empty |

## Verification
The packer's writes and the host's reads can fall in the same cycle. This is the case that breaks occupancy accounting and the full-queue drop rule. The bench provokes it by holding `rd_en` high during every packet in the motion sweeps, and by reading while the packer writes into a full queue. The bench compares every cycle's `rd_data` and `data_avail` against a byte-level model of the requirements. `clr` is also driven in the same cycle as an event and a read, and the bench expects `clr` to win.

// File: rtl/mpf_pkg.sv
package mpf_pkg;

    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_XMOT = 3'd1,
        S_YMOT = 3'd2,
        S_PAD1 = 3'd3,
        S_PAD2 = 3'd4
    } pk_state_e;

    localparam int unsigned BYTE_W    = 8;
    localparam logic [7:0]  START_IDLE = 8'h87;
    localparam logic [7:0]  PAD_BYTE   = 8'h00;

endpackage

// File: rtl/mpf_sat.sv
module mpf_sat #(
    parameter int unsigned IW = 10
) (
    input  logic signed [IW-1:0] val,
    output logic        [7:0]    code
);
    localparam logic signed [IW-1:0] HI_LIM = IW'(127);
    localparam logic signed [IW-1:0] LO_LIM = -HI_LIM;

    always_comb begin
        if (val > HI_LIM) begin
            code = 8'h7F;
        end else if (val < LO_LIM) begin
            code = 8'h81;
        end else begin
            code = val[7:0];
        end
    end
endmodule

// File: rtl/mpf_packer.sv
module mpf_packer #(
    parameter int unsigned MW = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  evt_valid,
    input  logic signed [MW-1:0]  evt_dx,
    input  logic signed [MW-1:0]  evt_dy,
    input  logic [2:0]            btns,
    output logic                  push_vld,
    output logic [7:0]            push_byte,
    output mpf_pkg::pk_state_e    state
);
    import mpf_pkg::*;

    localparam int unsigned EW = MW + 1;
    localparam int unsigned AXES = 2;

    pk_state_e st_q, st_nx;
    logic [7:0] x_q, y_q;
    logic [7:0] start_byte;
    logic       accept;

    logic signed [EW-1:0] axis_in  [AXES];
    logic        [7:0]    axis_out [AXES];

    always_comb begin
        axis_in[0] = {evt_dx[MW-1], evt_dx};
        axis_in[1] = -{evt_dy[MW-1], evt_dy};
    end

    for (genvar a = 0; a < AXES; a++) begin : g_axis
        mpf_sat #(.IW(EW)) sat_i (
            .val  (axis_in[a]),
            .code (axis_out[a])
        );
    end

    assign start_byte = START_IDLE ^ {5'b0, btns};
    assign accept     = (st_q == S_IDLE) && evt_valid;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= S_IDLE;
        end else if (clr) begin
            st_q <= S_IDLE;
        end else begin
            st_q <= st_nx;
        end
    end

    // captured motion bytes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q <= '0;
            y_q <= '0;
        end else if (accept && !clr) begin
            x_q <= axis_out[0];
            y_q <= axis_out[1];
        end
    end

    // next state
    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            S_IDLE: if (evt_valid) st_nx = S_XMOT;
            S_XMOT: st_nx = S_YMOT;
            S_YMOT: st_nx = S_PAD1;
            S_PAD1: st_nx = S_PAD2;
            S_PAD2: st_nx = S_IDLE;
            default: st_nx = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        push_vld  = 1'b0;
        push_byte = PAD_BYTE;
        unique case (st_q)
            S_IDLE: begin
                push_vld  = evt_valid;
                push_byte = start_byte;
            end
            S_XMOT: begin
                push_vld  = 1'b1;
                push_byte = x_q;
            end
            S_YMOT: begin
                push_vld  = 1'b1;
                push_byte = y_q;
            end
            S_PAD1, S_PAD2: begin
                push_vld  = 1'b1;
                push_byte = PAD_BYTE;
            end
            default: begin
                push_vld  = 1'b0;
                push_byte = PAD_BYTE;
            end
        endcase
    end

    assign state = st_q;
endmodule

// File: rtl/mpf_ring.sv
module mpf_ring #(
    parameter int unsigned DEPTH = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clr,
    input  logic                          push,
    input  logic [7:0]                    din,
    input  logic                          pop,
    output logic [7:0]                    dout,
    output logic                          not_empty,
    output logic [$clog2(DEPTH+1)-1:0]    count
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [7:0]    mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] cnt_q;
    logic          push_ok, pop_ok;

    assign push_ok = push && !clr && (cnt_q != FULL);
    assign pop_ok  = pop  && !clr && (cnt_q != '0);

    function automatic logic [PW-1:0] adv(input logic [PW-1:0] p);
        return (p == LAST) ? '0 : p + PW'(1);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (push_ok) wr_ptr <= adv(wr_ptr);
            if (pop_ok)  rd_ptr <= adv(rd_ptr);
            unique case ({push_ok, pop_ok})
                2'b10:   cnt_q <= cnt_q + CW'(1);
                2'b01:   cnt_q <= cnt_q - CW'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= din;
    end

    assign not_empty = (cnt_q != '0);
    assign dout      = not_empty ? mem[rd_ptr] : 8'h00;
    assign count     = cnt_q;
endmodule

// File: rtl/mouse_pkt_fifo.sv
module mouse_pkt_fifo #(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned MW    = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 evt_valid,
    input  logic signed [MW-1:0] evt_dx,
    input  logic signed [MW-1:0] evt_dy,
    input  logic                 btn_left,
    input  logic                 btn_mid,
    input  logic                 btn_right,
    input  logic                 rd_en,
    output logic [7:0]           rd_data,
    output logic                 data_avail
);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    mpf_pkg::pk_state_e pk_state;
    logic               push_vld;
    logic [7:0]         push_byte;
    logic [CW-1:0]      q_count;

    mpf_packer #(.MW(MW)) packer_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .evt_valid (evt_valid),
        .evt_dx    (evt_dx),
        .evt_dy    (evt_dy),
        .btns      ({btn_left, btn_mid, btn_right}),
        .push_vld  (push_vld),
        .push_byte (push_byte),
        .state     (pk_state)
    );

    mpf_ring #(.DEPTH(DEPTH)) ring_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .push      (push_vld),
        .din       (push_byte),
        .pop       (rd_en),
        .dout      (rd_data),
        .not_empty (data_avail),
        .count     (q_count)
    );
endmodule

// File: rtl/mpf_chk.sv
module mpf_chk #(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned CW    = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               clr,
    input logic               evt_valid,
    input logic               rd_en,
    input logic [7:0]         rd_data,
    input logic               data_avail,
    input mpf_pkg::pk_state_e st,
    input logic               push,
    input logic [CW-1:0]      cnt
);
    import mpf_pkg::*;

    assert_empty_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !data_avail |-> rd_data == 8'h00);

    assert_clear_empties_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!data_avail && st == S_IDLE));

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));

    assert_accept_moves_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_IDLE && evt_valid && !clr) |=> st == S_XMOT);

    assert_busy_ignores_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_XMOT && !clr) |=> st == S_YMOT);

    assert_avail_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && cnt > CW'(1) && !clr) |=> data_avail);

    assert_both_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && rd_en && !clr && cnt != '0 && cnt != CW'(DEPTH)) |=> $stable(cnt));

    assert_empty_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && cnt == '0 && !push && !clr) |=> cnt == '0);
endmodule

bind mouse_pkt_fifo mpf_chk #(.DEPTH(DEPTH), .CW($clog2(DEPTH + 1))) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .evt_valid  (evt_valid),
    .rd_en      (rd_en),
    .rd_data    (rd_data),
    .data_avail (data_avail),
    .st         (pk_state),
    .push       (push_vld),
    .cnt        (q_count)
);

// File: tb/mouse_pkt_fifo_tb_top.sv
`timescale 1ns/1ps
module mouse_pkt_fifo_tb_top;
    localparam int DEPTH = 6;
    localparam int MW    = 9;
    localparam int HALF  = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr = 1'b0;
    logic evt_valid = 1'b0;
    logic signed [MW-1:0] evt_dx = '0;
    logic signed [MW-1:0] evt_dy = '0;
    logic btn_left = 1'b0, btn_mid = 1'b0, btn_right = 1'b0;
    logic rd_en = 1'b0;
    logic [7:0] rd_data;
    logic data_avail;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    string cur_req = "R12";

    logic [7:0] mq[$];
    logic [7:0] pend[$];

    always #HALF clk = ~clk;

    mouse_pkt_fifo #(.DEPTH(DEPTH), .MW(MW)) dut_i (
        .clk(clk), .rst_n(rst_n), .clr(clr), .evt_valid(evt_valid),
        .evt_dx(evt_dx), .evt_dy(evt_dy), .btn_left(btn_left),
        .btn_mid(btn_mid), .btn_right(btn_right), .rd_en(rd_en),
        .rd_data(rd_data), .data_avail(data_avail)
    );

    function automatic logic [7:0] sat8(int v);
        int c;
        c = (v > 127) ? 127 : ((v < -127) ? -127 : v);
        return 8'(c);
    endfunction

    task automatic check_outputs();
        logic [7:0] exp_d;
        logic       exp_a;
        exp_a = (mq.size() > 0);
        exp_d = exp_a ? mq[0] : 8'h00;
        checks++;
        if (data_avail !== exp_a) begin
            errors++;
            $display("FAIL R9 (%s) data_avail actual %0b expected %0b", cur_req, data_avail, exp_a);
        end
        checks++;
        if (rd_data !== exp_d) begin
            errors++;
            $display("FAIL %s rd_data actual %02h expected %02h", cur_req, rd_data, exp_d);
        end
    endtask

    // one clock cycle: check at the falling edge, drive, update the model
    task automatic step(bit ev, int dx, int dy, bit [2:0] b, bit rd, bit c);
        @(negedge clk);
        #1;
        check_outputs();
        evt_valid = ev;
        evt_dx    = MW'(dx);
        evt_dy    = MW'(dy);
        {btn_left, btn_mid, btn_right} = b;
        rd_en     = rd;
        clr       = c;
        if (c) begin
            mq.delete();
            pend.delete();
        end else begin
            logic [7:0] pb;
            bit         pv;
            int         sz0;
            pv  = 0;
            pb  = 8'h00;
            sz0 = mq.size();
            if (pend.size() > 0) begin
                pb = pend.pop_front();
                pv = 1;
            end else if (ev) begin
                pb = 8'h87 ^ {5'b0, b};
                pv = 1;
                pend.push_back(sat8(dx));
                pend.push_back(sat8(-dy));
                pend.push_back(8'h00);
                pend.push_back(8'h00);
            end
            if (rd && sz0 > 0) void'(mq.pop_front());
            if (pv && sz0 < DEPTH) mq.push_back(pb);
        end
    endtask

    task automatic idle(int n, bit rd);
        for (int i = 0; i < n; i++) step(0, 0, 0, 3'b000, rd, 0);
    endtask

    initial begin
        #(2 * HALF * 200000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cur_req = "R12";
        idle(2, 0);

        cur_req = "R2";
        for (int b = 0; b < 8; b++) begin
            step(1, 5, -3, 3'(b), 1, 0);
            idle(6, 1);
        end

        cur_req = "R3";
        for (int dx = -256; dx < 256; dx++) begin
            step(1, dx, 0, 3'b000, 1, 0);
            idle(6, 1);
        end

        cur_req = "R4";
        for (int dy = -256; dy < 256; dy++) begin
            step(1, 0, dy, 3'b101, 1, 0);
            idle(6, 1);
        end

        cur_req = "R1";
        for (int k = 0; k < 40; k++) begin
            step(1, (k * 37) % 511 - 255, (k * 91) % 511 - 255, 3'(k), 0, 0);
            idle(4, 0);
            idle(6, 1);
        end

        cur_req = "R5";
        for (int i = 0; i < 12; i++) step(1, i * 20 - 100, 100 - i * 15, 3'(i), 1, 0);
        idle(8, 1);

        cur_req = "R6";
        for (int i = 0; i < 3; i++) begin
            step(1, i + 1, i + 2, 3'b111, 0, 0);
            idle(4, 0);
        end
        for (int i = 0; i < 2; i++) begin
            step(1, 60, -60, 3'b010, 1, 0);
            idle(4, 1);
        end
        idle(3, 1);

        cur_req = "R7";
        idle(4, 1);
        idle(2, 0);

        cur_req = "R8";
        step(1, 9, 9, 3'b000, 0, 0);
        idle(2, 0);
        step(0, 0, 0, 3'b000, 1, 0);
        step(0, 0, 0, 3'b000, 1, 0);
        step(1, -9, -9, 3'b001, 1, 0);
        idle(4, 1);
        idle(4, 1);

        cur_req = "R10";
        for (int k = 0; k < 30; k++) begin
            step(1, k, -k, 3'(k), 0, 0);
            idle(1, 0);
            idle(3, 1);
            idle(4, 1);
        end

        cur_req = "R11";
        step(1, 3, 4, 3'b000, 0, 0);
        step(0, 0, 0, 3'b000, 0, 1);
        idle(3, 1);
        step(1, 7, 7, 3'b000, 0, 0);
        idle(1, 0);
        step(1, 2, 2, 3'b011, 1, 1);
        idle(2, 0);
        step(1, 2, 2, 3'b011, 0, 0);
        idle(8, 1);

        @(negedge clk);
        #1;
        check_outputs();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule